// File: doc/BRIEF.md
# Variable-Precision 16-Bit Fraction Decoder

This block expands a 16-bit word held in a compact, variable-precision fractional number format into a 32-bit two's complement fixed-point value with 29 fractional bits. The word is sign-magnitude. The top bit gives the sign and the lower fifteen bits form a magnitude field. The field has no explicit exponent. The scale comes from the length of a run of zeros. Bit 0 of the field selects the end of the field where that run is counted. Precision drops by one mantissa bit for every two binary octaves that the value falls, so small values lose accuracy gradually and not all at once.

The word is decoded in a single register stage. Two priority detectors locate the terminating one from each end of the field. An aligner restores the implied leading one and places the mantissa at its binary weight. A sign stage negates the result when needed and recognises the one reserved code. A producer presents a word with `in_valid`. The decoded value and a reserved-code flag appear on the next clock edge, qualified by `out_valid`.

Top module: `irrfmt_decoder`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock edge. After reset `out_valid`, `out_data` and `out_special` are all 0.
- R2: When field bit 0 is 1, let n be the count of zeros from field bit 14 downward to the first 1, found at bit p = 14-n. The decoded magnitude is 1.M × 2^-(2n+1), where M is field bits p-1..1 (most significant first). Example: code 0x4001 gives 0x10000000 (0.5), and 0x2001 gives 0x04000000.
- R3: When field bit 0 is 0 and the field is nonzero, let n be the count of zeros from field bit 0 upward to the first 1. The decoded magnitude is 1.M × 2^-(2n), where M is field bits 14..n+1 (bit 14 first). Example: 0x0002 gives 0x08000000 (0.25), 0x7FFE gives 0x0FFFC000, and 0x4000 gives 0x00000002.
- R4: The largest code 0x7FFF decodes to (2 - 2^-13) × 2^-1 = 0x1FFF8000. No output ever needs more than 29 magnitude bits, so out_data bits 31..29 are always equal.
- R5: The smallest nonzero code 0x0001 decodes to 2^-29 = 0x00000001.
- R6: Code 0x0000 decodes to 0x00000000 with `out_special` low.
- R7: With sign bit 15 set and a nonzero field, `out_data` is the two's complement negation of the magnitude of the same field. Examples: 0x8001 gives 0xFFFFFFFF, and 0xFFFF gives 0xE0008000.
- R8: Code 0x8000 is reserved. It gives `out_data` = 0 and `out_special` = 1. Every other code gives `out_special` = 0.
- R9: In a cycle where `in_valid` is low, `in_data` is ignored and `out_data` and `out_special` keep their previous values.
- R10: All 65536 codes decode exactly, with no rounding, to the value that R2 to R8 define.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Marks `in_data` as a word to decode this cycle |
| in_data | input | 16 | Encoded word: bit 15 sign, bits 14..0 magnitude field |
| out_valid | output | 1 | `out_data` and `out_special` hold a fresh result |
| out_data | output | 32 | Decoded value, two's complement, 29 fractional bits |
| out_special | output | 1 | The decoded word was the reserved code 0x8000 |

## Verification
On every cycle the assertions check the one-cycle valid pipeline and the holding of results while input is idle. They also check the sign of the output against the sign bit of the input, the headroom of the upper three output bits, and the fixed results for zero, for the smallest code and for the reserved code. The exact value for each exponent run and mantissa pattern, for both scan directions, is shown only by the bench. The bench walks a directed vector table and then compares a full sweep of every code against an independent bit-by-bit model.

// File: rtl/irrfmt_pkg.sv
package irrfmt_pkg;

  // Width of the magnitude field inside the 16-bit word.
  localparam int unsigned FIELD_W = 15;
  // Width of the whole encoded word (sign plus field).
  localparam int unsigned WORD_W  = FIELD_W + 1;
  // Fraction bits needed so that every code lands exactly.
  localparam int unsigned FRAC_W  = 2 * FIELD_W - 1;
  // Width of a zero-run count (0 .. FIELD_W inclusive).
  localparam int unsigned CNT_W   = $clog2(FIELD_W + 1);

  // Direction in which a zero run is scanned.
  typedef enum logic {
    SCAN_FROM_TOP    = 1'b0,
    SCAN_FROM_BOTTOM = 1'b1
  } scan_dir_e;

  // Decoded fields of one input word, passed between stages.
  typedef struct packed {
    logic               sign;
    logic [FIELD_W-1:0] field;
  } code_t;

endpackage

// File: rtl/irrfmt_run_detect.sv
// Priority detector: number of zeros above the highest set bit of vec.
// Returns W when vec is all zero.
module irrfmt_run_detect #(
  parameter int unsigned W     = 15,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] zeros
);

  always_comb begin
    zeros = CNT_W'(W);
    // Lower bits are visited first so the highest set bit wins.
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        zeros = CNT_W'(W - 1 - i);
      end
    end
  end

endmodule

// File: rtl/irrfmt_align.sv
// Restores the implied one and places the mantissa at its binary weight.
module irrfmt_align #(
  parameter int unsigned FIELD_W = 15,
  parameter int unsigned CNT_W   = $clog2(FIELD_W + 1),
  parameter int unsigned MAG_W   = 2 * FIELD_W - 1
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [CNT_W-1:0]   top_zeros,
  input  logic [CNT_W-1:0]   bot_zeros,
  output logic [MAG_W-1:0]   magnitude
);

  localparam logic [CNT_W-1:0] FULL_RUN   = CNT_W'(FIELD_W);
  localparam logic [CNT_W-1:0] LAST_RUN   = CNT_W'(FIELD_W - 1);
  localparam logic [CNT_W-1:0] ONE_CNT    = CNT_W'(1);

  logic [MAG_W-1:0] odd_base;
  logic [MAG_W-1:0] odd_mag;
  logic [MAG_W-1:0] even_lead;
  logic [MAG_W-1:0] even_mant;
  logic [MAG_W-1:0] even_mag;
  logic [CNT_W-1:0] odd_shift;
  logic [CNT_W-1:0] even_shift;

  // Odd exponents: leading one sits high in the field, bit 0 is a marker.
  always_comb begin
    odd_base  = MAG_W'(field >> 1);
    odd_shift = FULL_RUN - top_zeros;
    if (top_zeros == LAST_RUN) begin
      // Only the marker bit is set: the smallest step of the format.
      odd_mag = MAG_W'(1);
    end else begin
      odd_mag = odd_base << odd_shift;
    end
  end

  // Even exponents: the terminating one is low, mantissa sits above it.
  always_comb begin
    even_shift = FULL_RUN - bot_zeros;
    even_lead  = MAG_W'(1) << (LAST_RUN - bot_zeros);
    even_mant  = MAG_W'(field) >> (bot_zeros + ONE_CNT);
    if (bot_zeros == FULL_RUN) begin
      even_mag = '0;
    end else begin
      even_mag = (even_lead | even_mant) << even_shift;
    end
  end

  assign magnitude = field[0] ? odd_mag : even_mag;

endmodule

// File: rtl/irrfmt_sign_apply.sv
// Applies the sign and recognises the reserved negative-zero code.
module irrfmt_sign_apply #(
  parameter int unsigned MAG_W = 29,
  parameter int unsigned OUT_W = 32
) (
  input  logic             sign,
  input  logic             field_zero,
  input  logic [MAG_W-1:0] magnitude,
  output logic [OUT_W-1:0] value,
  output logic             special
);

  logic [OUT_W-1:0] wide_mag;

  always_comb begin
    wide_mag = OUT_W'(magnitude);
    special  = sign & field_zero;
    if (special) begin
      value = '0;
    end else if (sign) begin
      value = ~wide_mag + OUT_W'(1);
    end else begin
      value = wide_mag;
    end
  end

endmodule

// File: rtl/irrfmt_decoder.sv
module irrfmt_decoder
  import irrfmt_pkg::*;
#(
  parameter int unsigned OUT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_special
);

  localparam int unsigned MAG_W = FRAC_W;

  // Reset release synchroniser; assertion stays asynchronous.
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  code_t code;
  assign code = code_t'(in_data);

  // Two scan directions share one detector design.
  logic [1:0][FIELD_W-1:0] scan_vec;
  logic [1:0][CNT_W-1:0]   run_len;

  for (genvar g = 0; g < 2; g++) begin : g_scan
    if (scan_dir_e'(g) == SCAN_FROM_TOP) begin : g_top
      assign scan_vec[g] = code.field;
    end else begin : g_bottom
      for (genvar b = 0; b < FIELD_W; b++) begin : g_rev
        assign scan_vec[g][b] = code.field[FIELD_W-1-b];
      end
    end
    irrfmt_run_detect #(
      .W     (FIELD_W),
      .CNT_W (CNT_W)
    ) u_detect (
      .vec   (scan_vec[g]),
      .zeros (run_len[g])
    );
  end

  logic [MAG_W-1:0] magnitude;

  irrfmt_align #(
    .FIELD_W (FIELD_W),
    .CNT_W   (CNT_W),
    .MAG_W   (MAG_W)
  ) u_align (
    .field     (code.field),
    .top_zeros (run_len[SCAN_FROM_TOP]),
    .bot_zeros (run_len[SCAN_FROM_BOTTOM]),
    .magnitude (magnitude)
  );

  logic             field_zero;
  logic [OUT_W-1:0] dec_value;
  logic             dec_special;

  assign field_zero = (run_len[SCAN_FROM_BOTTOM] == CNT_W'(FIELD_W));

  irrfmt_sign_apply #(
    .MAG_W (MAG_W),
    .OUT_W (OUT_W)
  ) u_sign (
    .sign       (code.sign),
    .field_zero (field_zero),
    .magnitude  (magnitude),
    .value      (dec_value),
    .special    (dec_special)
  );

  // Next-state logic with explicit load enable.
  logic             load_en;
  logic             valid_d;
  logic [OUT_W-1:0] data_d;
  logic             special_d;

  always_comb begin
    load_en   = in_valid;
    valid_d   = in_valid;
    data_d    = out_data;
    special_d = out_special;
    if (load_en) begin
      data_d    = dec_value;
      special_d = dec_special;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_special <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_data    <= data_d;
      out_special <= special_d;
    end
  end

endmodule

// File: rtl/irrfmt_decoder_chk.sv
module irrfmt_decoder_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned OUT_W  = 32,
  parameter int unsigned MAG_W  = 29
) (
  input logic              clk,
  input logic              rst_sync_q,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_special
);

  localparam logic [WORD_W-1:0] RESERVED = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] SMALLEST = WORD_W'(1);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    in_valid |=> out_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !in_valid |=> !out_valid);

  p_headroom_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_valid |-> (out_data[OUT_W-1:MAG_W] == '0 || out_data[OUT_W-1:MAG_W] == '1));

  p_smallest_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_data == SMALLEST) |=> out_data == OUT_W'(1));

  p_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_data == '0) |=> (out_data == '0 && !out_special));

  p_neg_sign_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_data[WORD_W-1] && in_data[WORD_W-2:0] != '0) |=> out_data[OUT_W-1]);

  p_pos_sign_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && !in_data[WORD_W-1]) |=> !out_data[OUT_W-1]);

  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_data == RESERVED) |=> (out_special && out_data == '0));

  p_not_reserved_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (in_valid && in_data != RESERVED) |=> !out_special);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !in_valid |=> ($stable(out_data) && $stable(out_special)));

endmodule

bind irrfmt_decoder irrfmt_decoder_chk #(
  .WORD_W (irrfmt_pkg::WORD_W),
  .OUT_W  (OUT_W),
  .MAG_W  (irrfmt_pkg::FRAC_W)
) u_chk (
  .clk         (clk),
  .rst_sync_q  (rst_sync_q),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_special (out_special)
);

// File: tb/irrfmt_decoder_bench.sv
`timescale 1ns/1ps
module irrfmt_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_special;

  int checks;
  int fails;
  bit done;

  irrfmt_decoder u_irrfmt_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_special (out_special)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Directed vectors: {code, expected value, expected special}.
  localparam logic [48:0] VEC [14] = '{
    {16'h0000, 32'h00000000, 1'b0},  // R6 zero
    {16'h4001, 32'h10000000, 1'b0},  // R2 0.5
    {16'h2001, 32'h04000000, 1'b0},  // R2 0.125
    {16'h0003, 32'h00000004, 1'b0},  // R2 2^-27
    {16'h7FFF, 32'h1FFF8000, 1'b0},  // R4 largest
    {16'h0001, 32'h00000001, 1'b0},  // R5 smallest
    {16'h0002, 32'h08000000, 1'b0},  // R3 0.25
    {16'h0004, 32'h02000000, 1'b0},  // R3 2^-4
    {16'h7FFE, 32'h0FFFC000, 1'b0},  // R3 full mantissa
    {16'h4000, 32'h00000002, 1'b0},  // R3 2^-28
    {16'h8001, 32'hFFFFFFFF, 1'b0},  // R7 -2^-29
    {16'hFFFF, 32'hE0008000, 1'b0},  // R7 most negative
    {16'hC001, 32'hF0000000, 1'b0},  // R7 -0.5
    {16'h8000, 32'h00000000, 1'b1}   // R8 reserved
  };

  task automatic check(input string req, input logic [15:0] code,
                       input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s code %h: actual %h expected %h", req, code, act, exp_v);
    end
  endtask

  // Independent bit-by-bit model of the format.
  function automatic logic [32:0] ref_decode(input logic [15:0] c);
    logic [14:0] f;
    longint acc;
    int n, p, w, k;
    logic [31:0] v;
    f = c[14:0];
    if (f == '0) begin
      return {c[15], 32'h0};
    end
    n = 0;
    acc = 1;
    if (f[0]) begin
      p = 14;
      while (!f[p]) begin n++; p--; end
      for (int j = p - 1; j >= 1; j--) acc = acc * 2 + longint'(f[j]);
      w = (p > 0) ? p - 1 : 0;
      k = 2 * n + 1;
    end else begin
      p = 0;
      while (!f[p]) begin n++; p++; end
      for (int j = 14; j >= p + 1; j--) acc = acc * 2 + longint'(f[j]);
      w = 14 - p;
      k = 2 * n;
    end
    acc = acc << (29 - w - k);
    v = c[15] ? 32'(-acc) : 32'(acc);
    return {1'b0, v};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [32:0] r;
    logic [31:0] held_data;
    logic        held_spc;
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 16'h1234;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", in_data, 32'(out_valid), 32'h0);
    check("R1 reset data", in_data, out_data, 32'h0);
    check("R1 reset special", in_data, 32'(out_special), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed table, one code per cycle.
    for (int i = 0; i < 14; i++) begin
      in_valid = 1'b1;
      in_data  = VEC[i][48:33];
      @(negedge clk);
      check("R1 valid", in_data, 32'(out_valid), 32'h1);
      check("R2/R3/R4/R5/R6/R7 value", in_data, out_data, VEC[i][32:1]);
      check("R8 special", in_data, 32'(out_special), 32'(VEC[i][0]));
    end

    // R9: idle cycles ignore in_data and hold the last result (reserved code).
    held_data = out_data;
    held_spc  = out_special;
    in_valid  = 1'b0;
    in_data   = 16'h4001;
    @(negedge clk);
    check("R1 idle valid", in_data, 32'(out_valid), 32'h0);
    check("R9 hold data", in_data, out_data, held_data);
    check("R9 hold special", in_data, 32'(out_special), 32'(held_spc));
    in_data = 16'h7FFF;
    @(negedge clk);
    check("R9 hold data 2", in_data, out_data, held_data);
    check("R9 hold special 2", in_data, 32'(out_special), 32'(held_spc));

    // R10: every code against the model.
    for (int c = 0; c < 65536; c++) begin
      in_valid = 1'b1;
      in_data  = 16'(c);
      @(negedge clk);
      r = ref_decode(16'(c));
      if (out_data !== r[31:0] || out_special !== r[32] || out_valid !== 1'b1) begin
        checks++;
        fails++;
        $display("FAIL R10 code %h: actual %h/%b expected %h/%b",
                 in_data, out_data, out_special, r[31:0], r[32]);
      end else begin
        checks++;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 final idle", in_data, 32'(out_valid), 32'h0);
    finish_run();
  end

endmodule